// File: doc/BRIEF.md
# Prescale-Extended PWM Channel

A single pulse-width-modulation channel driven by a small write-only register port. The count is 24 bits wide. It is built from a 16-bit main section plus an 8-bit prescale section that supplies the top byte. Software programs the period and the match (duty) point as a low halfword plus a high byte each. It also programs a mode word and a control word, then sets the enable bit. The counter then runs on its own, cycle after cycle.

Each transition of the final output pin can raise an event. The pin is taken after the optional inversion. A two-bit edge selector picks which transitions count. A sticky raw status bit records the event and is cleared by writing one. The interrupt line is that bit gated by an enable in the mode word and by a mask register. New period and match values take effect at the next reload, so a cycle in flight is never cut short or glitched.

Top module: `pwm24_channel`

## Requirements
- R1: After reset the pin, the raw status and the interrupt are all 0, and the channel is stopped.
- R2: The waveform runs only while mode bits [1:0] hold 2, bit 2 holds 0, bit 3 holds 1 and control bit 0 (enable) is 1. With any other mode value the pin stays 0.
- R3: The period P is {period-high byte (address 3), period-low halfword (address 2)}. One output cycle lasts P+1 clocks, and P may exceed 65535.
- R4: The match M is {match-high byte (address 5), match-low halfword (address 4)}. The non-inverted pin is high for P-M clocks of each cycle, and stays low when M >= P.
- R5: Control bit 3 inverts the pin, so the pin is high for M+1 clocks per cycle.
- R6: Control bits [2:1] select the event edge: 0 rising, 1 falling, 3 both, 2 none.
- R7: The selected edges are judged on the pin after inversion.
- R8: A period written while running leaves the current cycle's length unchanged and applies from the next cycle.
- R9: A match written while running leaves the current cycle's high time unchanged and applies from the next cycle.
- R10: The interrupt is high only when the raw status is 1, mode bit 4 is 1 and mask bit 0 (address 6) is 1.
- R11: Writing 1 to bit 0 of address 7 clears the raw status. An event in the same cycle wins, and the status stays 1.
- R12: Clearing enable drives the pin to 0 after one clock and stops the count. Setting enable again gives the first high pin sample two clocks after the write when M < P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 mode, 1 control, 2-5 period/match, 6 mask, 7 clear) |
| wr_data | input | 16 | Write data |
| pwm_o | output | 1 | PWM pin after inversion |
| evt_raw_o | output | 1 | Raw sticky event status |
| irq_o | output | 1 | Gated interrupt |

## Verification
The event detector and the software clear act on the same status bit, so they can land in the same clock. The bench waits for the first sample where the pin is high with rising edges selected, and drives the clear write immediately. The write is captured on the very edge where the detector fires. The status is judged afterwards and must read 1. A separate clear issued in a quiet phase must read 0, which shows the clear itself works.

// File: rtl/pwm24_channel.sv
module pwm24_channel #(
  parameter int LOW_W  = 16,
  parameter int HIGH_W = 8,
  parameter int AW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [LOW_W-1:0]  wr_data,
  output logic              pwm_o,
  output logic              evt_raw_o,
  output logic              irq_o
);
  localparam int TW = LOW_W + HIGH_W;
  localparam logic [AW-1:0] A_MODE = AW'(0);
  localparam logic [AW-1:0] A_CTRL = AW'(1);
  localparam logic [AW-1:0] A_PLO  = AW'(2);
  localparam logic [AW-1:0] A_PHI  = AW'(3);
  localparam logic [AW-1:0] A_MLO  = AW'(4);
  localparam logic [AW-1:0] A_MHI  = AW'(5);
  localparam logic [AW-1:0] A_MASK = AW'(6);
  localparam logic [AW-1:0] A_CLR  = AW'(7);

  logic [4:0]        mode_q;
  logic [3:0]        ctrl_q;
  logic [LOW_W-1:0]  per_lo_q, mat_lo_q;
  logic [HIGH_W-1:0] per_hi_q, mat_hi_q;
  logic              mask_q;
  logic [TW-1:0]     cnt_q, mat_act_q;
  logic              pwm_q, prev_q, status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0; ctrl_q <= '0; mask_q <= 1'b0;
      per_lo_q <= '0; per_hi_q <= '0; mat_lo_q <= '0; mat_hi_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_MODE: mode_q   <= wr_data[4:0];
        A_CTRL: ctrl_q   <= wr_data[3:0];
        A_PLO:  per_lo_q <= wr_data;
        A_PHI:  per_hi_q <= wr_data[HIGH_W-1:0];
        A_MLO:  mat_lo_q <= wr_data;
        A_MHI:  mat_hi_q <= wr_data[HIGH_W-1:0];
        A_MASK: mask_q   <= wr_data[0];
        default: ;
      endcase
    end
  end

  wire pwm_sel  = mode_q[3] & ~mode_q[2] & (mode_q[1:0] == 2'd2);
  wire active   = pwm_sel & ctrl_q[0];
  wire [TW-1:0] per_live = {per_hi_q, per_lo_q};
  wire [TW-1:0] mat_live = {mat_hi_q, mat_lo_q};
  wire clr_wr   = wr_en && (wr_addr == A_CLR) && wr_data[0];
  wire [1:0] ev = ctrl_q[2:1];
  wire on_rise  = (ev == 2'd0) || (ev == 2'd3);
  wire on_fall  = (ev == 2'd1) || (ev == 2'd3);
  wire rise     = pwm_q & ~prev_q;
  wire fall     = ~pwm_q & prev_q;
  wire edge_hit = active & ((rise & on_rise) | (fall & on_fall));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0; mat_act_q <= '0;
    end else if (!active) begin
      cnt_q <= '0;
    end else if (cnt_q == '0) begin
      cnt_q     <= per_live;
      mat_act_q <= mat_live;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q <= 1'b0; prev_q <= 1'b0; status_q <= 1'b0;
    end else begin
      pwm_q  <= active & ((cnt_q > mat_act_q) ^ ctrl_q[3]);
      prev_q <= pwm_q;
      if (edge_hit)    status_q <= 1'b1;
      else if (clr_wr) status_q <= 1'b0;
    end
  end

  assign pwm_o     = pwm_q;
  assign evt_raw_o = status_q;
  assign irq_o     = status_q & mode_q[4] & mask_q;

  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !pwm_o);
  p_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt_q == '0) |=> (cnt_q == $past(per_live) && mat_act_q == $past(mat_live)));
  p_setwins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> evt_raw_o);
  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !edge_hit) |=> !evt_raw_o);
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (cnt_q == '0));
endmodule

// File: tb/pwm24_channel_bench.sv
module pwm24_channel_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic pwm_o, evt_raw_o, irq_o;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm24_channel u_pwm24_channel (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_o(pwm_o), .evt_raw_o(evt_raw_o), .irq_o(irq_o));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    wr_en = 1'b1; wr_addr = a; wr_data = 16'(d);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setup(input int per, input int mat, input int mode, input int ctrl);
    wr(3'd1, 0);
    wr(3'd2, per & 16'hFFFF);
    wr(3'd3, (per >> 16) & 8'hFF);
    wr(3'd4, mat & 16'hFFFF);
    wr(3'd5, (mat >> 16) & 8'hFF);
    wr(3'd0, mode);
    wr(3'd7, 1);
    wr(3'd1, ctrl);
  endtask

  task automatic wait_level(input logic v);
    do @(negedge clk); while (pwm_o !== v);
  endtask

  task automatic sync_rise();
    wait_level(1'b0);
    wait_level(1'b1);
  endtask

  task automatic measure(output int hi, output int len);
    logic p;
    sync_rise();
    hi = 1; len = 1; p = 1'b1;
    forever begin
      @(negedge clk);
      if (pwm_o && !p) break;
      len++; hi += int'(pwm_o); p = pwm_o;
    end
  endtask

  task automatic count_high(input int cycles, output int hi);
    hi = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      hi += int'(pwm_o);
    end
  endtask

  task automatic t_reset();
    check("R1 pin", int'(pwm_o), 0);
    check("R1 status", int'(evt_raw_o), 0);
    check("R1 irq", int'(irq_o), 0);
  endtask

  task automatic t_basic();
    int hi, len;
    setup(9, 3, 'h0A, 1);
    measure(hi, len);
    check("R4 high P-M", hi, 6);
    check("R3 length P+1", len, 10);
    setup(9, 0, 'h0A, 1);
    measure(hi, len);
    check("R4 high match zero", hi, 9);
    check("R3 length match zero", len, 10);
    setup(12, 12, 'h0A, 1);
    count_high(40, hi);
    check("R4 match equals period stays low", hi, 0);
  endtask

  task automatic t_wide();
    int hi, len;
    setup('h010002, 'h010000, 'h0A, 1);
    measure(hi, len);
    check("R4 high byte of match", hi, 2);
    check("R3 high byte of period", len, 'h010003);
  endtask

  task automatic t_mode();
    int hi;
    int bad[3] = '{'h02, 'h0E, 'h09};
    foreach (bad[i]) begin
      setup(9, 3, bad[i], 1);
      count_high(40, hi);
      check("R2 bad mode idle", hi, 0);
    end
    wr(3'd0, 'h0A);
    count_high(20, hi);
    check("R2 good mode runs", int'(hi > 0), 1);
  endtask

  task automatic t_invert();
    int hi, len;
    setup(9, 3, 'h0A, 1 | 8);
    measure(hi, len);
    check("R5 inverted high M+1", hi, 4);
    check("R5 inverted length", len, 10);
  endtask

  task automatic t_defer_period();
    int n, len, hi;
    logic p;
    setup(19, 5, 'h0A, 1);
    sync_rise();
    wr(3'd2, 29);
    n = 2; p = pwm_o;
    forever begin
      @(negedge clk);
      if (pwm_o && !p) break;
      n++; p = pwm_o;
    end
    check("R8 current cycle keeps old period", n, 20);
    measure(hi, len);
    check("R8 next cycle uses new period", len, 30);
  endtask

  task automatic t_defer_duty();
    int n, h, len, hi;
    logic p;
    setup(19, 5, 'h0A, 1);
    sync_rise();
    wr(3'd4, 15);
    h = 1 + int'(pwm_o); n = 2; p = pwm_o;
    forever begin
      @(negedge clk);
      if (pwm_o && !p) break;
      n++; h += int'(pwm_o); p = pwm_o;
    end
    check("R9 current cycle keeps old match", h, 14);
    measure(hi, len);
    check("R9 next cycle uses new match", hi, 4);
  endtask

  task automatic check_edges(input string req, input int exp_rise, input int exp_fall);
    wait_level(1'b1);
    wait_level(1'b0);
    repeat (3) @(negedge clk);
    wr(3'd7, 1);
    check({req, " cleared"}, int'(evt_raw_o), 0);
    wait_level(1'b1);
    @(negedge clk);
    check({req, " on rise"}, int'(evt_raw_o), exp_rise);
    repeat (3) @(negedge clk);
    wr(3'd7, 1);
    check({req, " cleared high"}, int'(evt_raw_o), 0);
    wait_level(1'b0);
    @(negedge clk);
    check({req, " on fall"}, int'(evt_raw_o), exp_fall);
  endtask

  task automatic t_events();
    setup(39, 19, 'h0A, 1 | (0 << 1));
    check_edges("R6 rising", 1, 0);
    setup(39, 19, 'h0A, 1 | (1 << 1));
    check_edges("R6 falling", 0, 1);
    setup(39, 19, 'h0A, 1 | (3 << 1));
    check_edges("R6 both", 1, 1);
    setup(39, 19, 'h0A, 1 | (2 << 1));
    check_edges("R6 none", 0, 0);
    setup(39, 9, 'h0A, 1 | 8 | (0 << 1));
    check_edges("R7 rising on inverted pin", 1, 0);
    setup(39, 9, 'h0A, 1 | 8 | (1 << 1));
    check_edges("R7 falling on inverted pin", 0, 1);
  endtask

  task automatic t_irq();
    setup(19, 5, 'h0A, 1);
    sync_rise();
    @(negedge clk);
    check("R10 status set", int'(evt_raw_o), 1);
    wr(3'd6, 1);
    check("R10 enable off", int'(irq_o), 0);
    wr(3'd6, 0);
    wr(3'd0, 'h1A);
    check("R10 mask off", int'(irq_o), 0);
    wr(3'd6, 1);
    check("R10 both on", int'(irq_o), 1);
    wr(3'd7, 1);
    check("R10 cleared status drops irq", int'(irq_o), 0);
    wr(3'd6, 0);
    wr(3'd0, 'h0A);
  endtask

  task automatic t_collide();
    setup(19, 5, 'h0A, 1);
    wait_level(1'b1);
    wait_level(1'b0);
    repeat (2) @(negedge clk);
    wr(3'd7, 1);
    check("R11 quiet clear", int'(evt_raw_o), 0);
    wait_level(1'b1);
    wr_en = 1'b1; wr_addr = 3'd7; wr_data = 16'd1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    check("R11 set wins over clear", int'(evt_raw_o), 1);
  endtask

  task automatic t_disable();
    int hi;
    setup(19, 5, 'h0A, 1);
    wait_level(1'b1);
    wr(3'd1, 0);
    @(negedge clk);
    check("R12 pin low after disable", int'(pwm_o), 0);
    count_high(50, hi);
    check("R12 stays low", hi, 0);
    wr(3'd1, 1);
    @(negedge clk);
    check("R12 restart first sample", int'(pwm_o), 0);
    @(negedge clk);
    check("R12 restart second sample", int'(pwm_o), 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_mode();
    t_invert();
    t_defer_period();
    t_defer_duty();
    t_events();
    t_irq();
    t_collide();
    t_disable();
    t_wide();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL all requirements: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule